// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose pins behind a small word-addressed register interface. Software chooses, per pin, whether the pin is driven (from an output data register under a per-pin output enable) and can always read the synchronized level of every pin. Each pin input passes through a two-flop synchronizer. A third flop keeps the previous synchronized sample, so edges are found by comparing the current sample with that stored one.

Every pin has its own interrupt detector. Three independent configuration bits choose its behaviour: a sense bit (level or edge), a both-edges bit and a polarity bit. Events are latched into a sticky raw status register. A mask register gates the raw status into a masked status view. The OR of the masked view, registered once, is the single summary interrupt line. Software acknowledges an event by writing ones to a write-one-to-clear register. An integrator who needs more pins places several banks side by side and decodes a bank select above this block's address bits.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, and `pin_out`, `pin_oe` and `irq` are 0. A read strobe returns the addressed register on `bus_rdata` one cycle later. `bus_rdata` is 0 on cycles that follow no read, and on reads of unmapped word indices 10 to 15.
- R2: Word index 1 (byte 0x04) is the output data register and drives `pin_out`. Word index 2 (byte 0x08) is the output enable register and drives `pin_oe`, where 1 means the pin is driven. Both take effect on the clock edge of the write and read back what was written.
- R3: Word index 0 (byte 0x00) returns the pin levels through a two-flop synchronizer, whatever the output enable holds. A read issued in the cycle after a pin change still returns the old level. A read issued two cycles after the change returns the new level.
- R4: With sense bit 0 (word index 3, byte 0x0C) and both-edges bit 0 (word index 4, byte 0x10), polarity bit 1 (word index 5, byte 0x14) latches a rising edge into raw status. Polarity bit 0 latches a falling edge instead. An edge of the opposite direction sets nothing.
- R5: With sense bit 0 and both-edges bit 1, both rising and falling edges set raw status, whatever the polarity bit holds.
- R6: With sense bit 1, the pin sets raw status while it sits at the active level (high for polarity 1, low for polarity 0). The status bit stays set after the level goes away. A clear of a bit whose level is still active drops it for exactly one cycle, and it is set again on the next cycle.
- R7: Writing ones to word index 9 (byte 0x24) clears those raw status bits. Zero bits leave status unchanged, and reading this word returns 0.
- R8: Word index 6 (byte 0x18) is the mask, where 1 enables the pin. Word index 8 (byte 0x20) reads raw status AND mask. The mask does not change raw status.
- R9: `irq` equals the OR of the masked status one cycle earlier. It is 0 while every pending bit is masked.
- R10: An edge event that reaches status in the same cycle as a clear write for that pin is kept, so no edge is lost.
- R11: Raw status (word index 7, byte 0x1C) and masked status (word index 8) ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 6 | Byte address, word aligned; bits 5:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| pin_in | input | NPINS (32) | Asynchronous pin levels |
| pin_out | output | NPINS (32) | Output data to the pads |
| pin_oe | output | NPINS (32) | Output enable to the pads, 1 drives |
| irq | output | 1 | Registered summary interrupt |

## Verification
Some relations are checked by properties on every clock: a synchronized edge is always captured in status even when a clear arrives with it, an active level is always captured unless cleared in that cycle, the summary line tracks the masked status with one cycle of delay, output-enable writes reach the pins, and clear-register and masked-status reads return the right words. Other behaviours need a scripted sequence and a cycle-accurate model, so only the bench scenarios can show them: the exact two-read latency of the input view, the single-cycle drop and reassertion of a cleared level bit, that a level bit stays sticky after the level goes away, that an edge of the wrong direction is ignored, and that writes to the status words change nothing.

// File: rtl/gpio_bank_pkg.sv
// Package: register index map and bus widths shared by the GPIO bank.
// Assumes a 32-bit data bus with word-aligned byte addresses.
package gpio_bank_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;
    localparam int ADDR_W = IDX_W + 2;

    typedef enum logic [IDX_W-1:0] {
        REG_DIN   = 4'd0,
        REG_DOUT  = 4'd1,
        REG_OE    = 4'd2,
        REG_SENSE = 4'd3,
        REG_BOTH  = 4'd4,
        REG_POL   = 4'd5,
        REG_MASK  = 4'd6,
        REG_RAW   = 4'd7,
        REG_MSTAT = 4'd8,
        REG_CLR   = 4'd9
    } reg_idx_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer for a vector of pins, plus one history flop.
// Assumes each pin is an independent asynchronous signal; no bus coherency.
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta;

    // Purpose: shift pins through two stages and keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            cur  <= '0;
            prev <= '0;
        end else begin
            meta <= raw_in;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/gpio_evt_detect.sv
// Module: per-pin event detector and sticky raw status.
// Assumes cur/prev are synchronized samples one cycle apart. A clear of a
// level-sensed bit wins for one cycle; an edge arriving with a clear wins.
module gpio_evt_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] sense_lvl,
    input  logic [W-1:0] both_edge,
    input  logic [W-1:0] pol_high,
    input  logic [W-1:0] clr,
    output logic [W-1:0] stat
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic hit;
        logic st_q;

        // Purpose: decide whether this pin shows an event in this cycle.
        always_comb begin
            if (sense_lvl[i])      hit = (cur[i] == pol_high[i]);
            else if (both_edge[i]) hit = cur[i] ^ prev[i];
            else if (pol_high[i])  hit = cur[i] & ~prev[i];
            else                   hit = ~cur[i] & prev[i];
        end

        // Purpose: hold the event until software clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)                     st_q <= 1'b0;
            else if (clr[i] && sense_lvl[i]) st_q <= 1'b0;
            else                            st_q <= (st_q & ~clr[i]) | hit;
        end

        assign stat[i] = st_q;
    end
endmodule

// File: rtl/gpio_irq_bank.sv
// Module: one GPIO bank with register file, input sync, interrupt
// detection and a registered summary interrupt.
// Assumes single-cycle read/write strobes; read data is registered.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    reg_idx_e         sel;
    logic [NPINS-1:0] dout_q, oe_q, sense_q, both_q, pol_q, mask_q;
    logic [NPINS-1:0] pin_cur, pin_prev, raw_stat, clr_vec, wr_bits;
    logic [DATA_W-1:0] rd_word;

    assign sel     = reg_idx_e'(bus_addr[ADDR_W-1:2]);
    assign wr_bits = bus_wdata[NPINS-1:0];

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pin_in),
        .cur    (pin_cur),
        .prev   (pin_prev)
    );

    // Purpose: form the one-cycle clear pulse from a write to the clear word.
    always_comb begin
        clr_vec = (bus_wr && sel == REG_CLR) ? wr_bits : '0;
    end

    gpio_evt_detect #(.W(NPINS)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (pin_cur),
        .prev      (pin_prev),
        .sense_lvl (sense_q),
        .both_edge (both_q),
        .pol_high  (pol_q),
        .clr       (clr_vec),
        .stat      (raw_stat)
    );

    // Purpose: update the writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            oe_q    <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            mask_q  <= '0;
        end else if (bus_wr) begin
            case (sel)
                REG_DOUT:  dout_q  <= wr_bits;
                REG_OE:    oe_q    <= wr_bits;
                REG_SENSE: sense_q <= wr_bits;
                REG_BOTH:  both_q  <= wr_bits;
                REG_POL:   pol_q   <= wr_bits;
                REG_MASK:  mask_q  <= wr_bits;
                default: ;
            endcase
        end
    end

    // Purpose: select the word returned for a read.
    always_comb begin
        rd_word = '0;
        case (sel)
            REG_DIN:   rd_word[NPINS-1:0] = pin_cur;
            REG_DOUT:  rd_word[NPINS-1:0] = dout_q;
            REG_OE:    rd_word[NPINS-1:0] = oe_q;
            REG_SENSE: rd_word[NPINS-1:0] = sense_q;
            REG_BOTH:  rd_word[NPINS-1:0] = both_q;
            REG_POL:   rd_word[NPINS-1:0] = pol_q;
            REG_MASK:  rd_word[NPINS-1:0] = mask_q;
            REG_RAW:   rd_word[NPINS-1:0] = raw_stat;
            REG_MSTAT: rd_word[NPINS-1:0] = raw_stat & mask_q;
            default:   rd_word = '0;
        endcase
    end

    // Purpose: register read data and the summary interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            irq       <= 1'b0;
        end else begin
            bus_rdata <= bus_rd ? rd_word : '0;
            irq       <= |(raw_stat & mask_q);
        end
    end

    assign pin_out = dout_q;
    assign pin_oe  = oe_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Module: property checker for gpio_irq_bank, attached by bind.
// Assumes it observes the bank's ports and its internal sample/status nets.
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq,
    input logic [NPINS-1:0]  cur,
    input logic [NPINS-1:0]  prev,
    input logic [NPINS-1:0]  sense_lvl,
    input logic [NPINS-1:0]  both_edge,
    input logic [NPINS-1:0]  pol_high,
    input logic [NPINS-1:0]  mask,
    input logic [NPINS-1:0]  stat
);
    logic [IDX_W-1:0]  idx;
    logic [NPINS-1:0]  clr_seen, edge_hit, lvl_hit;
    logic [DATA_W-1:0] mstat_word;

    // Purpose: derive watched vectors independently of the design's logic.
    always_comb begin
        idx        = bus_addr[ADDR_W-1:2];
        clr_seen   = (bus_wr && idx == REG_CLR) ? bus_wdata[NPINS-1:0] : '0;
        edge_hit   = ~sense_lvl & ((cur & ~prev & (pol_high | both_edge)) |
                                   (~cur & prev & (~pol_high | both_edge)));
        lvl_hit    = sense_lvl & ~(cur ^ pol_high) & ~clr_seen;
        mstat_word = '0;
        mstat_word[NPINS-1:0] = stat & mask;
    end

    // R4, R5 and R10: an edge is captured even when a clear arrives with it.
    assert_edge_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_hit) |=> ((stat & $past(edge_hit)) == $past(edge_hit)));

    assert_level_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|lvl_hit) |=> ((stat & $past(lvl_hit)) == $past(lvl_hit)));

    assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(stat & mask)));

    assert_oe_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == REG_OE) |=> (pin_oe == $past(bus_wdata[NPINS-1:0])));

    assert_clear_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && idx == REG_CLR) |=> (bus_rdata == '0));

    assert_masked_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && idx == REG_MSTAT) |=> (bus_rdata == $past(mstat_word)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .cur       (pin_cur),
    .prev      (pin_prev),
    .sense_lvl (sense_q),
    .both_edge (both_q),
    .pol_high  (pol_q),
    .mask      (mask_q),
    .stat      (raw_stat)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;

    gpio_irq_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    // Behavioural reference state
    logic [31:0] m_dout, m_oe, m_lvl, m_both, m_pol, m_mask, m_stat;
    logic [31:0] m_s1, m_s2, m_prev, m_rdata, t_rd, t_clr, t_next;
    logic        m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dout = 0; m_oe = 0; m_lvl = 0; m_both = 0; m_pol = 0; m_mask = 0;
            m_stat = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_rdata = 0; m_irq = 0;
        end else begin
            t_rd = 0;
            if (bus_rd) begin
                case (bus_addr >> 2)
                    0: t_rd = m_s2;
                    1: t_rd = m_dout;
                    2: t_rd = m_oe;
                    3: t_rd = m_lvl;
                    4: t_rd = m_both;
                    5: t_rd = m_pol;
                    6: t_rd = m_mask;
                    7: t_rd = m_stat;
                    8: t_rd = m_stat & m_mask;
                    default: t_rd = 0;
                endcase
            end
            t_clr = (bus_wr && (bus_addr >> 2) == 9) ? bus_wdata : 0;
            for (int i = 0; i < 32; i++) begin
                bit ev;
                if (m_lvl[i]) ev = m_pol[i] ? m_s2[i] : !m_s2[i];
                else if (m_both[i]) ev = (m_s2[i] != m_prev[i]);
                else if (m_pol[i]) ev = m_s2[i] && !m_prev[i];
                else ev = !m_s2[i] && m_prev[i];
                if (t_clr[i] && m_lvl[i]) t_next[i] = 1'b0;
                else t_next[i] = (m_stat[i] && !t_clr[i]) || ev;
            end
            m_irq = |(m_stat & m_mask);
            m_stat = t_next;
            m_rdata = t_rd;
            if (bus_wr) begin
                case (bus_addr >> 2)
                    1: m_dout = bus_wdata;
                    2: m_oe = bus_wdata;
                    3: m_lvl = bus_wdata;
                    4: m_both = bus_wdata;
                    5: m_pol = bus_wdata;
                    6: m_mask = bus_wdata;
                    default: ;
                endcase
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    // Every-clock comparison with the reference model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 pin_out vs model", pin_out, m_dout);
            check("R2 pin_oe vs model", pin_oe, m_oe);
            check("R9 irq vs model", {31'b0, irq}, {31'b0, m_irq});
            check("R1 bus_rdata vs model", bus_rdata, m_rdata);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic summary_and_end;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary_and_end();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1: reset state
        for (int k = 0; k < 10; k++) rd_chk(6'(k * 4), 32'h0, "R1 reset register value");
        check("R1 pin_oe after reset", pin_oe, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd_chk(6'h3C, 32'h0, "R1 unmapped read");

        // R2: output data and enable
        wr(6'h04, 32'hA5A5_0F0F);
        wr(6'h08, 32'hFFFF_0000);
        check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        rd_chk(6'h04, 32'hA5A5_0F0F, "R2 dout readback");
        rd_chk(6'h08, 32'hFFFF_0000, "R2 oe readback");

        // R3: input view latency
        pin_in = 32'h1234_5678;
        cyc(1);
        rd_chk(6'h00, 32'h0, "R3 input one cycle after change");
        rd_chk(6'h00, 32'h1234_5678, "R3 input two cycles after change");

        // Settle pins low and clear everything
        pin_in = 32'h0;
        cyc(4);
        wr(6'h24, 32'hFFFF_FFFF);
        rd_chk(6'h1C, 32'h0, "R7 clear all");

        // R4: single-edge polarity
        wr(6'h14, 32'h1);
        wr(6'h18, 32'h1);
        pin_in = 32'h1; cyc(4);
        rd_chk(6'h1C, 32'h1, "R4 rising edge with polarity 1");
        check("R9 irq raised by unmasked bit", {31'b0, irq}, 32'h1);
        pin_in = 32'h2; cyc(4);
        rd_chk(6'h1C, 32'h1, "R4 opposite edges ignored");
        pin_in = 32'h0; cyc(4);
        rd_chk(6'h1C, 32'h3, "R4 falling edge with polarity 0");
        rd_chk(6'h20, 32'h1, "R8 masked status");

        // R7: write-one-to-clear
        wr(6'h24, 32'h2);
        rd_chk(6'h1C, 32'h1, "R7 clear one bit");
        wr(6'h24, 32'h0);
        rd_chk(6'h1C, 32'h1, "R7 zero write has no effect");
        rd_chk(6'h24, 32'h0, "R7 clear word reads zero");
        wr(6'h24, 32'h1);
        cyc(2);
        rd_chk(6'h1C, 32'h0, "R7 clear last bit");
        check("R9 irq low after clear", {31'b0, irq}, 32'h0);

        // R5: both edges, polarity 0
        wr(6'h10, 32'h4);
        pin_in = 32'h4; cyc(4);
        rd_chk(6'h1C, 32'h4, "R5 rising edge in dual mode");
        wr(6'h24, 32'h4);
        pin_in = 32'h0; cyc(4);
        rd_chk(6'h1C, 32'h4, "R5 falling edge in dual mode");
        wr(6'h24, 32'h4);
        wr(6'h10, 32'h0);

        // R6: level sensing
        wr(6'h14, 32'h9);
        wr(6'h0C, 32'h18);
        cyc(3);
        rd_chk(6'h1C, 32'h10, "R6 low level active, high level idle");
        wr(6'h24, 32'h10);
        rd_chk(6'h1C, 32'h0, "R6 cleared for one cycle");
        rd_chk(6'h1C, 32'h10, "R6 reasserts while level present");
        pin_in = 32'h18; cyc(3);
        rd_chk(6'h1C, 32'h18, "R6 sticky after level leaves");
        wr(6'h24, 32'h18);
        cyc(1);
        rd_chk(6'h1C, 32'h08, "R6 only active level reasserts");
        wr(6'h0C, 32'h0);
        pin_in = 32'h0; cyc(4);
        wr(6'h24, 32'hFFFF_FFFF);
        rd_chk(6'h1C, 32'h0, "R7 clear all after level test");

        // R10: edge coinciding with clear
        wr(6'h14, 32'h20);
        pin_in = 32'h20;
        cyc(2);
        wr(6'h24, 32'h20);
        rd_chk(6'h1C, 32'h20, "R10 edge kept against clear");

        // R11 and R8: status words ignore writes, mask gates view
        wr(6'h1C, 32'hFFFF_FFFF);
        wr(6'h20, 32'hFFFF_FFFF);
        rd_chk(6'h1C, 32'h20, "R11 raw status ignores write");
        rd_chk(6'h20, 32'h0, "R8 masked view hides bit");
        wr(6'h18, 32'h20);
        rd_chk(6'h20, 32'h20, "R8 masked view shows bit");
        rd_chk(6'h1C, 32'h20, "R8 mask leaves raw status");
        cyc(1);
        check("R9 irq after unmask", {31'b0, irq}, 32'h1);
        rd_chk(6'h28, 32'h0, "R1 unmapped index 10");

        cyc(2);
        summary_and_end();
    end
endmodule